// File: doc/BRIEF.md
# Framed register job requester

This block drives read and write jobs into an eight-entry byte register target over a framed byte stream. Each beat of the stream carries a valid/accept pair and first/last markers. On the user side the block takes a single-cycle command with a direction bit, a 4-bit register address and a write byte. It turns the command into one or two request beats. It then follows the target's framed reply until the closing status beat arrives, and hands the read byte and an error bit back to the user alongside a one-cycle done pulse.

The outgoing beat is held steady under backpressure. The incoming channel may pause for any number of cycles between beats. While a job is in flight the block reports busy and drops any new command. Incoming beats that do not fit the expected reply shape are consumed and discarded.

Top module: `reg_job_requester`

## Requirements
- R1: While reset (active low) is asserted and after it is released, req_valid, rsp_accept, busy and done are low and the block waits for a command.
- R2: A command is taken when cmd_valid is high and busy is low. busy is high from the next cycle until the done cycle, in which it is low again. A command offered while busy is dropped and produces no request beat.
- R3: The first request beat of a job carries the address in bits 7:4 and the operation in bits 3:0, with code 0 for read and 1 for write. No other operation code is ever emitted.
- R4: A read job sends exactly one request beat, with both req_first and req_last high.
- R5: A write job sends a first beat with req_first high and req_last low, followed by a beat with req_first low, req_last high and the write byte.
- R6: While req_valid is high and req_accept is low, req_valid, req_first, req_last and req_byte keep their values. The next beat appears only after a cycle with req_accept high.
- R7: rsp_accept is high only after all request beats of a job have been accepted and before the job's done cycle.
- R8: A read reply is taken as a first beat, then a middle beat (neither marker), then a last beat, and the middle byte is returned on rd_data. A write reply is a first beat followed by a last beat, and rd_data is 0 for a write job.
- R9: done is high for exactly one cycle, the cycle after the closing beat is accepted. In that cycle err reports the closing byte: 0 means success and any nonzero value means error. The target reports an error for addresses 8 to 15.
- R10: Gaps of any length in rsp_valid between reply beats are tolerated. A beat that does not match the expected position in the reply (for example a last beat before any first beat) is consumed and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_write | input | 1 | 1 = write job, 0 = read job |
| cmd_addr | input | 4 | Register address |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Job in flight |
| done | output | 1 | One-cycle job completion pulse |
| rd_data | output | 8 | Byte returned by a read job |
| err | output | 1 | Target reported an error |
| req_valid | output | 1 | Request beat present |
| req_first | output | 1 | Request beat opens a frame |
| req_last | output | 1 | Request beat closes a frame |
| req_byte | output | 8 | Request beat payload |
| req_accept | input | 1 | Target takes the request beat |
| rsp_valid | input | 1 | Reply beat present |
| rsp_first | input | 1 | Reply beat opens a frame |
| rsp_last | input | 1 | Reply beat closes a frame |
| rsp_byte | input | 8 | Reply beat payload |
| rsp_accept | output | 1 | Block takes the reply beat |

## Verification
The hardest situations to create from the ports are out-of-shape reply beats and commands that arrive mid-job, because a well-behaved target never produces them. The bench plays the target itself. A vector table varies direction, address, accept stalls and reply gaps. Directed jobs then inject a stray closing beat (with error byte 1) before the reply header, offer a second command while the first waits for its reply, and pull reset while a request beat is being held.

// File: rtl/reg_job_requester.sv
module reg_job_requester #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          err,
  output logic          req_valid,
  output logic          req_first,
  output logic          req_last,
  output logic [DW-1:0] req_byte,
  input  logic          req_accept,
  input  logic          rsp_valid,
  input  logic          rsp_first,
  input  logic          rsp_last,
  input  logic [DW-1:0] rsp_byte,
  output logic          rsp_accept
);
  localparam int CW = DW - AW;
  localparam logic [CW-1:0] OP_RD = '0;
  localparam logic [CW-1:0] OP_WR = CW'(1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TX_HDR, ST_TX_DAT, ST_RX_HDR, ST_RX_DAT, ST_RX_FTR
  } state_t;

  state_t        st;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  logic beat_mid, beat_open, beat_close;
  assign beat_open  = rsp_valid &  rsp_first & ~rsp_last;
  assign beat_mid   = rsp_valid & ~rsp_first & ~rsp_last;
  assign beat_close = rsp_valid & ~rsp_first &  rsp_last;

  assign busy       = (st != ST_IDLE);
  assign req_valid  = (st == ST_TX_HDR) || (st == ST_TX_DAT);
  assign req_first  = (st == ST_TX_HDR);
  assign req_last   = ((st == ST_TX_HDR) && !wr_q) || (st == ST_TX_DAT);
  assign req_byte   = (st == ST_TX_HDR) ? {addr_q, (wr_q ? OP_WR : OP_RD)} :
                      (st == ST_TX_DAT) ? wdata_q : '0;
  assign rsp_accept = (st == ST_RX_HDR) || (st == ST_RX_DAT) || (st == ST_RX_FTR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          wr_q    <= cmd_write;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          rd_data <= '0;
          err     <= 1'b0;
          st      <= ST_TX_HDR;
        end
        ST_TX_HDR: if (req_accept) st <= wr_q ? ST_TX_DAT : ST_RX_HDR;
        ST_TX_DAT: if (req_accept) st <= ST_RX_HDR;
        ST_RX_HDR: if (beat_open) st <= wr_q ? ST_RX_FTR : ST_RX_DAT;
        ST_RX_DAT: if (beat_mid) begin
          rd_data <= rsp_byte;
          st      <= ST_RX_FTR;
        end
        ST_RX_FTR: if (beat_close) begin
          err  <= (rsp_byte != '0);
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reg_job_requester_chk.sv
module reg_job_requester_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          req_valid,
  input logic          req_first,
  input logic          req_last,
  input logic [DW-1:0] req_byte,
  input logic          req_accept,
  input logic          rsp_valid,
  input logic          rsp_first,
  input logic          rsp_last,
  input logic          rsp_accept
);
  localparam int CW = DW - AW;

  a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_accept |=> req_valid && $stable(req_byte) && $stable(req_first) && $stable(req_last));

  a_r3_legal_op: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_first |-> req_byte[CW-1:1] == '0);

  a_r5_markers: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_first || req_last));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_accept);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rsp_valid && rsp_last && !rsp_first && rsp_accept));

  a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rsp_accept);

  a_r2_take_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid |=> busy && req_valid && req_first);
endmodule

bind reg_job_requester reg_job_requester_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err(err), .req_valid(req_valid), .req_first(req_first), .req_last(req_last),
  .req_byte(req_byte), .req_accept(req_accept), .rsp_valid(rsp_valid),
  .rsp_first(rsp_first), .rsp_last(rsp_last), .rsp_accept(rsp_accept)
);

// File: tb/reg_job_requester_tb.sv
module reg_job_requester_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [3:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       busy, done, err, req_valid, req_first, req_last, rsp_accept;
  logic [7:0] rd_data, req_byte;
  logic       req_accept = 1'b0;
  logic       rsp_valid = 1'b0, rsp_first = 1'b0, rsp_last = 1'b0;
  logic [7:0] rsp_byte = '0;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [7:0] regs [8];

  always #5 clk = ~clk;

  reg_job_requester u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .err(err), .req_valid(req_valid), .req_first(req_first),
    .req_last(req_last), .req_byte(req_byte), .req_accept(req_accept),
    .rsp_valid(rsp_valid), .rsp_first(rsp_first), .rsp_last(rsp_last),
    .rsp_byte(rsp_byte), .rsp_accept(rsp_accept)
  );

  // entry: {write, addr[3:0], wdata[7:0], stall[3:0], gap[3:0]}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'd0,  8'hA5, 4'd0, 4'd0},
    {1'b1, 4'd7,  8'h3C, 4'd2, 4'd1},
    {1'b0, 4'd0,  8'h00, 4'd0, 4'd0},
    {1'b0, 4'd7,  8'h00, 4'd3, 4'd2},
    {1'b1, 4'd9,  8'hFF, 4'd1, 4'd0},
    {1'b0, 4'd12, 8'h00, 4'd0, 4'd3},
    {1'b1, 4'd3,  8'h81, 4'd0, 4'd2},
    {1'b0, 4'd3,  8'h00, 4'd1, 4'd0},
    {1'b0, 4'd5,  8'h00, 4'd2, 4'd1},
    {1'b1, 4'd15, 8'h00, 4'd0, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic get_beat(input int stall, output logic [7:0] b, output logic f, output logic l);
    while (!req_valid) @(negedge clk);
    b = req_byte; f = req_first; l = req_last;
    chk(rsp_accept == 1'b0, "R7 accept low while sending", rsp_accept, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(req_valid && req_byte == b && req_first == f && req_last == l,
          "R6 beat held", {req_valid, req_first, req_last, req_byte}, {1'b1, f, l, b});
    end
    req_accept = 1'b1;
    @(negedge clk);
    req_accept = 1'b0;
  endtask

  task automatic send_beat(input int gap, input logic f, input logic l, input logic [7:0] b);
    for (int i = 0; i < gap; i++) @(negedge clk);
    rsp_valid = 1'b1; rsp_first = f; rsp_last = l; rsp_byte = b;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_first = 1'b0; rsp_last = 1'b0; rsp_byte = '0;
  endtask

  task automatic do_job(input logic wr, input logic [3:0] a, input logic [7:0] wd,
                        input int stall, input int gap, input bit stray, input bit poke);
    logic [7:0] b; logic f, l; logic [7:0] exp_rd; logic exp_err;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after command", busy, 1);
    get_beat(stall, b, f, l);
    chk(b == {a, (wr ? 4'h1 : 4'h0)}, "R3 header byte", b, {a, (wr ? 4'h1 : 4'h0)});
    if (wr) begin
      chk(f == 1'b1 && l == 1'b0, "R5 write header markers", {f, l}, 2'b10);
      get_beat(stall, b, f, l);
      chk(b == wd && f == 1'b0 && l == 1'b1, "R5 write data beat", {f, l, b}, {2'b01, wd});
    end else begin
      chk(f == 1'b1 && l == 1'b1, "R4 read single beat", {f, l}, 2'b11);
    end
    chk(req_valid == 1'b0 && rsp_accept == 1'b1, "R7 accept while awaiting reply",
        {req_valid, rsp_accept}, 2'b01);
    if (poke) begin
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd2; cmd_wdata = 8'h55;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    exp_err = (a > 4'd7);
    if (!exp_err && wr) regs[a[2:0]] = wd;
    exp_rd = (!wr && !exp_err) ? regs[a[2:0]] : 8'h00;
    if (stray) begin
      send_beat(0, 1'b0, 1'b1, 8'h01);
      chk(done == 1'b0 && busy == 1'b1, "R10 stray closing beat ignored", {done, busy}, 2'b01);
    end
    send_beat(gap, 1'b1, 1'b0, 8'h00);
    if (!wr) send_beat(gap, 1'b0, 1'b0, exp_rd);
    send_beat(gap, 1'b0, 1'b1, {7'd0, exp_err});
    chk(done == 1'b1 && busy == 1'b0, "R9 done after footer", {done, busy}, 2'b10);
    chk(err == exp_err, "R9 error bit", err, exp_err);
    chk(rd_data == exp_rd, "R8 returned data", rd_data, exp_rd);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!req_valid && !rsp_accept && !busy && !done, "R1 reset state",
        {req_valid, rsp_accept, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !rsp_accept && !busy && !done, "R1 idle after release",
        {req_valid, rsp_accept, busy, done}, 0);

    for (int k = 0; k < NV; k++)
      do_job(VEC[k][20], VEC[k][19:16], VEC[k][15:8], int'(VEC[k][7:4]), int'(VEC[k][3:0]), 1'b0, 1'b0);

    // R10: stray closing beat before header, with gaps
    do_job(1'b0, 4'd3, 8'h00, 0, 2, 1'b1, 1'b0);

    // R2: command offered while busy is dropped
    do_job(1'b0, 4'd7, 8'h00, 1, 0, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      chk(req_valid == 1'b0 && busy == 1'b0, "R2 dropped command sends nothing",
          {req_valid, busy}, 0);
      @(negedge clk);
    end
    do_job(1'b0, 4'd2, 8'h00, 0, 0, 1'b0, 1'b0);

    // R1: reset while a request beat is held
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd1; cmd_wdata = 8'h11;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req_valid == 1'b1, "R6 beat presented", req_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!req_valid && !busy && !rsp_accept && !done, "R1 reset mid-job",
        {req_valid, busy, rsp_accept, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_job(1'b0, 4'd1, 8'h00, 0, 1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule